// File: doc/BRIEF.md
# Prescaled 16-bit General-Purpose Timer

This block is a 16-bit event timer driven by the system clock through a programmable 16-bit divider. Software sets the divider value, the count direction and the restart behaviour in a single control word. It loads a starting value into the count register and then sets the run bit. Each divided tick moves the counter one step up or down. When a step lands on the terminal value, the block latches a status flag. That flag raises the interrupt output if its enable is set. After the terminal step the timer either halts or reloads the last written start value and keeps counting.

The register port is a plain single-cycle write strobe with a combinational read. Word addresses are 0 for control, 1 for count, 2 for status and 3 for interrupt enable. The divider is held in reset while the timer is not active. Every start therefore sees a full divider period before the first step.

Top module: `pscl_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq` is low.
- R2: The control word has the enable flag at bit 0, the direction flag at bit 2 (1 = up, 0 = down), the restart flag at bit 3, the run flag at bit 5 and the divider value N at bits [31:16]; all other bits read back as zero.
- R3: The count does not change unless the enable flag and the run flag are both 1, apart from register writes to the count.
- R4: While active, the count steps once every N+1 clocks. The first step comes N+1 clocks after run is set, because the divider restarts from zero whenever the timer is inactive.
- R5: When counting down, each step subtracts one, and a step that lands on 0 is a terminal step.
- R6: When counting up, each step adds one, and a step that lands on 16'hFFFF is a terminal step.
- R7: With the restart flag at 0, a terminal step leaves the count at the terminal value and clears the run flag, so counting stops.
- R8: With the restart flag at 1, a terminal step loads the value most recently written to the count register, and the run flag stays set.
- R9: Status bit 0 is set by a terminal step. Writing 1 to status bit 0 clears it, writing 0 leaves it unchanged, and a terminal step in the same cycle as a clear wins.
- R10: `irq` is high exactly when status bit 0 and interrupt-enable bit 0 are both 1.
- R11: A write to the count register (bits [15:0]) takes effect at the next clock edge, even while the timer is running, and also becomes the restart value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_addr | input | 2 | Word address: 0 control, 1 count, 2 status, 3 interrupt enable |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
The checker checks on every cycle that an inactive timer holds its count, and that status and `irq` rise only after a terminal step or an enable write. It also checks that run drops only on a control write or a halting terminal step, that a terminal step happens only from the value next to the terminal one, and that two ticks never come back to back when N is non-zero. The exact tick spacing, the first-tick latency after a restart, the reload value and the read-back layout can be shown only by the bench. The bench does this by sweeping small divider values and start counts in both directions and in both restart modes.

// File: rtl/pscl_timer_pkg.sv
package pscl_timer_pkg;
    localparam int DATA_W  = 32;
    localparam int ADDR_W  = 2;
    localparam int PSC_W   = 16;
    localparam int PSC_LSB = 16;
    localparam int B_EN    = 0;
    localparam int B_UP    = 2;
    localparam int B_AUTO  = 3;
    localparam int B_RUN   = 5;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL = 2'd0,
        A_CNT  = 2'd1,
        A_STS  = 2'd2,
        A_IEN  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [PSC_W-1:0] psc;
        logic             run;
        logic             auto_rl;
        logic             up;
        logic             en;
    } ctrl_t;

    function automatic ctrl_t unpack_ctrl(input logic [DATA_W-1:0] w);
        ctrl_t c;
        c.psc     = w[PSC_LSB +: PSC_W];
        c.run     = w[B_RUN];
        c.auto_rl = w[B_AUTO];
        c.up      = w[B_UP];
        c.en      = w[B_EN];
        return c;
    endfunction

    function automatic logic [DATA_W-1:0] pack_ctrl(input ctrl_t c);
        logic [DATA_W-1:0] w;
        w = '0;
        w[PSC_LSB +: PSC_W] = c.psc;
        w[B_RUN]  = c.run;
        w[B_AUTO] = c.auto_rl;
        w[B_UP]   = c.up;
        w[B_EN]   = c.en;
        return w;
    endfunction
endpackage

// File: rtl/pscl_timer_regs.sv
module pscl_timer_regs
    import pscl_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              term_hit,
    output ctrl_t             ctrl_q,
    output logic [CNT_W-1:0]  reload_q,
    output logic              sts_q,
    output logic              ien_q,
    output logic              cnt_load
);
    logic wr_ctrl, wr_cnt, wr_sts, wr_ien;

    assign wr_ctrl  = wr && (addr == A_CTRL);
    assign wr_cnt   = wr && (addr == A_CNT);
    assign wr_sts   = wr && (addr == A_STS);
    assign wr_ien   = wr && (addr == A_IEN);
    assign cnt_load = wr_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            reload_q <= '0;
            sts_q    <= 1'b0;
            ien_q    <= 1'b0;
        end else begin
            if (wr_ctrl)
                ctrl_q <= unpack_ctrl(wdata);
            else if (term_hit && !ctrl_q.auto_rl)
                ctrl_q.run <= 1'b0;
            if (wr_cnt)
                reload_q <= wdata[CNT_W-1:0];
            if (term_hit)
                sts_q <= 1'b1;
            else if (wr_sts && wdata[0])
                sts_q <= 1'b0;
            if (wr_ien)
                ien_q <= wdata[0];
        end
    end
endmodule

// File: rtl/pscl_timer_div.sv
module pscl_timer_div #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             active,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);
    logic [PSC_W-1:0] pcnt;

    // >= keeps a shrinking divider value from sending pcnt round the wrap
    assign tick = active && (pcnt >= psc);

    always_ff @(posedge clk) begin
        if (rst || !active)
            pcnt <= '0;
        else if (tick)
            pcnt <= '0;
        else
            pcnt <= pcnt + 1'b1;
    end
endmodule

// File: rtl/pscl_timer_cnt.sv
module pscl_timer_cnt #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             up,
    input  logic             auto_rl,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             term_hit
);
    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    logic [CNT_W-1:0] step;
    logic [CNT_W-1:0] term_val;

    assign step     = up ? cnt + 1'b1 : cnt - 1'b1;
    assign term_val = up ? TOP : '0;
    assign term_hit = tick && (step == term_val);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (tick)
            cnt <= (term_hit && auto_rl) ? reload : step;
    end
endmodule

// File: rtl/pscl_timer.sv
module pscl_timer
    import pscl_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [1:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq
);
    ctrl_t            ctrl_q;
    logic [CNT_W-1:0] reload_q;
    logic [CNT_W-1:0] cnt;
    logic             sts_q, ien_q, cnt_load;
    logic             active, tick, term_hit;

    assign active = ctrl_q.en && ctrl_q.run;

    pscl_timer_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .term_hit (term_hit),
        .ctrl_q   (ctrl_q),
        .reload_q (reload_q),
        .sts_q    (sts_q),
        .ien_q    (ien_q),
        .cnt_load (cnt_load)
    );

    pscl_timer_div #(.PSC_W(PSC_W)) u_div (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .psc    (ctrl_q.psc),
        .tick   (tick)
    );

    pscl_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tick     (tick),
        .up       (ctrl_q.up),
        .auto_rl  (ctrl_q.auto_rl),
        .load     (cnt_load),
        .load_val (bus_wdata[CNT_W-1:0]),
        .reload   (reload_q),
        .cnt      (cnt),
        .term_hit (term_hit)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_CTRL:  bus_rdata = pack_ctrl(ctrl_q);
            A_CNT:   bus_rdata[CNT_W-1:0] = cnt;
            A_STS:   bus_rdata[0] = sts_q;
            default: bus_rdata[0] = ien_q;
        endcase
    end

    assign irq = sts_q && ien_q;
endmodule

// File: rtl/pscl_timer_chk.sv
module pscl_timer_chk
    import pscl_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              wr,
    input logic [1:0]        addr,
    input logic              run,
    input logic              up,
    input logic              active,
    input logic              tick,
    input logic              term_hit,
    input logic              sts,
    input logic              irq,
    input logic [PSC_W-1:0]  psc,
    input logic [CNT_W-1:0]  cnt
);
    localparam logic [CNT_W-1:0] NEAR_TOP = {{(CNT_W-1){1'b1}}, 1'b0};

    // R3
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!active && !(wr && addr == A_CNT)) |=> $stable(cnt));

    // R4
    tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (tick && psc != '0 && !(wr && addr == A_CTRL)) |=> !tick);

    // R5
    term_from_edge_chk: assert property (@(posedge clk) disable iff (rst)
        term_hit |-> (up ? (cnt == NEAR_TOP) : (cnt == {{(CNT_W-1){1'b0}}, 1'b1})));

    // R7
    run_drop_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(run) |-> ($past(wr && addr == A_CTRL) || $past(term_hit)));

    // R9
    sts_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sts) |-> $past(term_hit));

    // R10
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> ($past(term_hit) || $past(wr && addr == A_IEN)));
endmodule

bind pscl_timer pscl_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr       (bus_wr),
    .addr     (bus_addr),
    .run      (ctrl_q.run),
    .up       (ctrl_q.up),
    .active   (active),
    .tick     (tick),
    .term_hit (term_hit),
    .sts      (sts_q),
    .irq      (irq),
    .psc      (ctrl_q.psc),
    .cnt      (cnt)
);

// File: tb/sim_pscl_timer.sv
module sim_pscl_timer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    pscl_timer u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    function automatic logic [31:0] mk(int psc, bit run, bit rl, bit up, bit en);
        return (32'(psc) << 16) | (32'(run) << 5) | (32'(rl) << 3) | (32'(up) << 2) | 32'(en);
    endfunction

    task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic wr(logic [1:0] a, logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [1:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic waitn(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk_reg(string req, logic [1:0] a, logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        for (int a = 0; a < 4; a++) chk_reg("R1 reg", 2'(a), 32'h0);
        chk("R1 irq", 32'(irq), 32'h0);

        // R2 layout, R3 no count while enable low
        wr(1, 32'd7);
        wr(0, 32'h1234_FFEE);
        chk_reg("R2 readback", 0, 32'h1234_002C);
        waitn(5);
        chk_reg("R3 en low", 1, 32'd7);
        wr(0, mk(0, 0, 0, 0, 1));
        waitn(5);
        chk_reg("R3 run low", 1, 32'd7);

        // R4 R5 R7 R9 sweep, down-counting without restart
        for (int n = 0; n < 4; n++) begin
            for (int l = 1; l <= 4; l++) begin
                wr(0, 32'h0);
                wr(2, 32'h1);
                wr(1, 32'(l));
                wr(0, mk(n, 1, 0, 0, 1));
                waitn((n + 1) * l - 1);
                chk_reg("R4 R5 before terminal", 1, 32'd1);
                chk_reg("R9 status before", 2, 32'd0);
                waitn(1);
                chk_reg("R5 terminal count", 1, 32'd0);
                chk_reg("R9 status set", 2, 32'd1);
                rd(0, v);
                chk("R7 run cleared", 32'(v[5]), 32'd0);
                waitn(n + 3);
                chk_reg("R7 held", 1, 32'd0);
            end
        end

        // R4 divider restarts after a stop
        wr(0, 32'h0);
        wr(1, 32'd9);
        wr(0, mk(3, 1, 0, 0, 1));
        waitn(1);
        wr(0, mk(3, 0, 0, 0, 1));
        chk_reg("R4 stopped early", 1, 32'd9);
        wr(0, mk(3, 1, 0, 0, 1));
        waitn(3);
        chk_reg("R4 full period after restart", 1, 32'd9);
        waitn(1);
        chk_reg("R4 first tick", 1, 32'd8);
        waitn(4);
        chk_reg("R4 second tick", 1, 32'd7);

        // R6 R8 up with restart
        wr(0, 32'h0);
        wr(2, 32'h1);
        wr(1, 32'hFFFD);
        wr(0, mk(1, 1, 1, 1, 1));
        waitn(2);
        chk_reg("R6 up step", 1, 32'hFFFE);
        waitn(2);
        chk_reg("R8 reload up", 1, 32'hFFFD);
        chk_reg("R9 status up", 2, 32'd1);
        rd(0, v);
        chk("R8 run kept", 32'(v[5]), 32'd1);
        waitn(2);
        chk_reg("R8 continues", 1, 32'hFFFE);

        // R6 R7 up without restart
        wr(0, 32'h0);
        wr(2, 32'h1);
        wr(1, 32'hFFFE);
        wr(0, mk(0, 1, 0, 1, 1));
        waitn(1);
        chk_reg("R6 top", 1, 32'hFFFF);
        chk_reg("R6 status", 2, 32'd1);
        rd(0, v);
        chk("R7 up run cleared", 32'(v[5]), 32'd0);

        // R8 down with restart
        wr(0, 32'h0);
        wr(2, 32'h1);
        wr(1, 32'd2);
        wr(0, mk(0, 1, 1, 0, 1));
        waitn(1);
        chk_reg("R8 down step", 1, 32'd1);
        waitn(1);
        chk_reg("R8 reload down", 1, 32'd2);
        waitn(1);
        chk_reg("R8 down again", 1, 32'd1);

        // R9 clear semantics
        wr(0, 32'h0);
        chk_reg("R9 set before clear", 2, 32'd1);
        wr(2, 32'h0);
        chk_reg("R9 write 0 ignored", 2, 32'd1);
        wr(2, 32'h1);
        chk_reg("R9 write 1 clears", 2, 32'd0);

        // R10 interrupt gating
        wr(1, 32'hFFFE);
        wr(0, mk(0, 1, 0, 1, 1));
        waitn(2);
        chk("R10 irq masked", 32'(irq), 32'd0);
        wr(3, 32'h1);
        chk_reg("R10 enable readback", 3, 32'd1);
        chk("R10 irq raised", 32'(irq), 32'd1);
        wr(2, 32'h1);
        chk("R10 irq cleared", 32'(irq), 32'd0);

        // R11 count write while running
        wr(1, 32'd5);
        wr(0, mk(100, 1, 0, 0, 1));
        waitn(3);
        wr(1, 32'd40);
        chk_reg("R11 live write", 1, 32'd40);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule